// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves data on its own between two address ranges, one element at a time. Software programs a source-side pointer (the peripheral address), a memory pointer, an element count and a control word. Then it sets the enable bit. Each element is a read on a simple bus master port followed by a write of the fetched data. A direction bit picks which pointer is read and which is written.

In peripheral mode each element waits for a request pulse from the attached peripheral. In memory-to-memory mode the channel runs as soon as it is enabled. Circular mode reloads the count and both pointers when a round ends, so a ring buffer keeps being serviced.

Three status flags report events: half way, complete and bus error. A summary flag is the OR of the three, and one interrupt line combines the flags with their enables. A bus error turns the channel off in hardware. The priority field is only stored and read back.

Top module: `dma_chan`

## Requirements
- R1: After reset the channel is disabled, all registers and flags read 0, `bus_req_o` is 0 and `irq_o` is 0.
- R2: Register map: 0 control, 1 peripheral address, 2 memory address, 3 count, 4 status. While control bit 0 (enable) is 1, writes to registers 1-3 and to control bits 1 (dir), 2 (circ), 3 (pinc) and 4 (minc) are ignored. The other control fields stay writable: [6:5] peripheral width, [8:7] memory width, 9 mem-to-mem, [11:10] priority, 12/13/14 half/complete/error interrupt enables.
- R3: Each element is a read of the source pointer followed by a write of the same data, zero-extended from the source width, to the destination pointer. Dir 0 makes the peripheral pointer the source; dir 1 makes the memory pointer the source. `bus_size_o` carries the width code of the access.
- R4: Width codes 0, 1 and 2 mean 8, 16 and 32 bits. When its increment bit is 1, a pointer advances by 1, 2 or 4 after each element; when the bit is 0 it holds.
- R5: In memory-to-memory mode transfers start without requests. In peripheral mode, each one-cycle pulse on `preq_i` allows exactly one element, and no element starts without one.
- R6: The remaining count decrements by one per completed element and reads back at address 3 while enabled. In non-circular mode the channel goes idle at 0. Enabling with a count of 0 issues no bus access.
- R7: In circular mode, reaching 0 reloads the count and both pointers from the programmed values and transfers continue. Circular mode has no effect while mem-to-mem is set.
- R8: The half flag (status bit 2) sets on the element where twice the remaining count first drops below the programmed count.
- R9: The complete flag (status bit 1) sets when the remaining count reaches 0.
- R10: A bus error sets the error flag (status bit 3), clears the enable bit and suppresses the write of that element.
- R11: Status bit 0 is the OR of bits 1-3. Writing 1 to a status bit 1-3 clears it. `irq_o` is the OR of each flag ANDed with its interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| preq_i | input | 1 | Peripheral request pulse |
| bus_req_o | output | 1 | Bus access request |
| bus_addr_o | output | 32 | Bus address |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_size_o | output | 2 | Access width code |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data |
| bus_ready_i | input | 1 | Access completes this cycle |
| bus_err_i | input | 1 | Access failed |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a locked-register write that lands in the middle of a circular run. It only shows up in the destination addresses and in the reload value several elements later. The bench therefore rewrites the peripheral address, memory address, count and direction between two requests in circular mode. A scoreboard then holds every later write to the original address sequence, and the readback count after the second wrap has to match the original reload value. The bus error case points the source pointer at the reserved top address region, so the failing access is the very first read.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_PADDR  = 1;
  localparam int unsigned REG_MADDR  = 2;
  localparam int unsigned REG_COUNT  = 3;
  localparam int unsigned REG_STATUS = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_st_e;

  typedef struct packed {
    logic       teie;
    logic       tcie;
    logic       htie;
    logic [1:0] prio;
    logic       m2m;
    logic [1:0] mw;
    logic [1:0] pw;
    logic       minc;
    logic       pinc;
    logic       circ;
    logic       dir;
  } cfg_t;

  function automatic logic [2:0] width_step(input logic [1:0] w);
    case (w)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] width_mask(input logic [31:0] d, input logic [1:0] w);
    case (w)
      2'd0:    return {24'b0, d[7:0]};
      2'd1:    return {16'b0, d[15:0]};
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  input  logic          inc_i,
  input  logic [1:0]    width_i,
  output logic [AW-1:0] ptr_o
);
  import dma_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ptr_o <= '0;
    else if (load_i)        ptr_o <= base_i;
    else if (adv_i && inc_i) ptr_o <= ptr_o + {{(AW-3){1'b0}}, width_step(width_i)};
  end
endmodule

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int unsigned AW  = 32,
  parameter int unsigned CW  = 16,
  parameter int unsigned RAW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  input  logic [CW-1:0]  cnt_cur_i,
  input  logic           set_tc_i,
  input  logic           set_ht_i,
  input  logic           set_te_i,
  output logic           ch_en_o,
  output dma_pkg::cfg_t  cfg_o,
  output logic [AW-1:0]  paddr_o,
  output logic [AW-1:0]  maddr_o,
  output logic [CW-1:0]  cnt_init_o,
  output logic           flag_tc_o,
  output logic           flag_ht_o,
  output logic           flag_te_o,
  output logic           irq_o
);
  import dma_pkg::*;

  logic wr_ctrl, wr_stat;
  assign wr_ctrl = reg_we_i && (reg_addr_i == RAW'(REG_CTRL));
  assign wr_stat = reg_we_i && (reg_addr_i == RAW'(REG_STATUS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_en_o    <= 1'b0;
      cfg_o      <= '0;
      paddr_o    <= '0;
      maddr_o    <= '0;
      cnt_init_o <= '0;
      flag_tc_o  <= 1'b0;
      flag_ht_o  <= 1'b0;
      flag_te_o  <= 1'b0;
    end else begin
      if (set_te_i)     ch_en_o <= 1'b0;
      else if (wr_ctrl) ch_en_o <= reg_wdata_i[0];
      if (wr_ctrl) begin
        cfg_o.pw   <= reg_wdata_i[6:5];
        cfg_o.mw   <= reg_wdata_i[8:7];
        cfg_o.m2m  <= reg_wdata_i[9];
        cfg_o.prio <= reg_wdata_i[11:10];
        cfg_o.htie <= reg_wdata_i[12];
        cfg_o.tcie <= reg_wdata_i[13];
        cfg_o.teie <= reg_wdata_i[14];
        if (!ch_en_o) begin
          cfg_o.dir  <= reg_wdata_i[1];
          cfg_o.circ <= reg_wdata_i[2];
          cfg_o.pinc <= reg_wdata_i[3];
          cfg_o.minc <= reg_wdata_i[4];
        end
      end
      if (reg_we_i && !ch_en_o) begin
        if (reg_addr_i == RAW'(REG_PADDR)) paddr_o    <= reg_wdata_i[AW-1:0];
        if (reg_addr_i == RAW'(REG_MADDR)) maddr_o    <= reg_wdata_i[AW-1:0];
        if (reg_addr_i == RAW'(REG_COUNT)) cnt_init_o <= reg_wdata_i[CW-1:0];
      end
      // set beats clear
      flag_tc_o <= set_tc_i | (flag_tc_o & ~(wr_stat & reg_wdata_i[1]));
      flag_ht_o <= set_ht_i | (flag_ht_o & ~(wr_stat & reg_wdata_i[2]));
      flag_te_o <= set_te_i | (flag_te_o & ~(wr_stat & reg_wdata_i[3]));
    end
  end

  assign irq_o = (flag_tc_o & cfg_o.tcie) | (flag_ht_o & cfg_o.htie) | (flag_te_o & cfg_o.teie);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RAW'(REG_CTRL):   reg_rdata_o = {17'b0, cfg_o.teie, cfg_o.tcie, cfg_o.htie, cfg_o.prio,
                                       cfg_o.m2m, cfg_o.mw, cfg_o.pw, cfg_o.minc, cfg_o.pinc,
                                       cfg_o.circ, cfg_o.dir, ch_en_o};
      RAW'(REG_PADDR):  reg_rdata_o[AW-1:0] = paddr_o;
      RAW'(REG_MADDR):  reg_rdata_o[AW-1:0] = maddr_o;
      RAW'(REG_COUNT):  reg_rdata_o[CW-1:0] = ch_en_o ? cnt_cur_i : cnt_init_o;
      RAW'(REG_STATUS): reg_rdata_o[3:0] = {flag_te_o, flag_ht_o, flag_tc_o,
                                            flag_te_o | flag_ht_o | flag_tc_o};
      default:          reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ch_en_i,
  input  logic          dir_i,
  input  logic          circ_i,
  input  logic          m2m_i,
  input  logic          pinc_i,
  input  logic          minc_i,
  input  logic [1:0]    pw_i,
  input  logic [1:0]    mw_i,
  input  logic [AW-1:0] paddr_i,
  input  logic [AW-1:0] maddr_i,
  input  logic [CW-1:0] cnt_init_i,
  input  logic          preq_i,
  output logic          bus_req_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_we_o,
  output logic [1:0]    bus_size_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ready_i,
  input  logic          bus_err_i,
  output logic [CW-1:0] cnt_o,
  output logic          set_tc_o,
  output logic          set_ht_o,
  output logic          set_te_o
);
  import dma_pkg::*;

  localparam int unsigned NPTR = 2; // 0 peripheral, 1 memory

  eng_st_e           st_q;
  logic              en_q, pend_q, start, go, take, done, circ_eff, reload;
  logic [DW-1:0]     data_q;
  logic [CW-1:0]     cnt_nxt;
  logic [CW:0]       dbl_old, dbl_new, init_x;
  logic [NPTR-1:0][AW-1:0] base, ptr;
  logic [NPTR-1:0]         inc;
  logic [NPTR-1:0][1:0]    wid;
  logic [AW-1:0]     src_ptr, dst_ptr;
  logic [1:0]        src_w, dst_w;

  assign base = {maddr_i, paddr_i};
  assign inc  = {minc_i, pinc_i};
  assign wid  = {mw_i, pw_i};

  generate
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      dma_ptr #(.AW(AW)) u_ptr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (start | reload),
        .base_i  (base[g]),
        .adv_i   (done & ~reload),
        .inc_i   (inc[g]),
        .width_i (wid[g]),
        .ptr_o   (ptr[g])
      );
    end
  endgenerate

  assign src_ptr  = dir_i ? ptr[1] : ptr[0];
  assign dst_ptr  = dir_i ? ptr[0] : ptr[1];
  assign src_w    = dir_i ? mw_i : pw_i;
  assign dst_w    = dir_i ? pw_i : mw_i;
  assign circ_eff = circ_i & ~m2m_i;

  assign start   = ch_en_i & ~en_q;
  assign go      = ch_en_i & en_q & (st_q == ST_IDLE) & (cnt_o != '0) & (m2m_i | pend_q);
  assign take    = go & ~m2m_i;
  assign done    = ch_en_i & (st_q == ST_WR) & bus_ready_i & ~bus_err_i;
  assign cnt_nxt = cnt_o - 1'b1;
  assign reload  = done & (cnt_nxt == '0) & circ_eff;

  assign dbl_old  = {cnt_o, 1'b0};
  assign dbl_new  = {cnt_nxt, 1'b0};
  assign init_x   = {1'b0, cnt_init_i};
  assign set_tc_o = done & (cnt_nxt == '0);
  assign set_ht_o = done & (dbl_old >= init_x) & (dbl_new < init_x);
  assign set_te_o = bus_req_o & bus_ready_i & bus_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      cnt_o  <= '0;
      data_q <= '0;
    end else begin
      en_q   <= ch_en_i;
      pend_q <= ch_en_i & ((pend_q & ~take) | preq_i);
      if (start)       cnt_o <= cnt_init_i;
      else if (reload) cnt_o <= cnt_init_i;
      else if (done)   cnt_o <= cnt_nxt;
      if (!ch_en_i) st_q <= ST_IDLE;
      else begin
        case (st_q)
          ST_IDLE: if (go) st_q <= ST_RD;
          ST_RD: if (bus_ready_i) begin
            st_q   <= bus_err_i ? ST_IDLE : ST_WR;
            data_q <= bus_rdata_i;
          end
          ST_WR:   if (bus_ready_i) st_q <= ST_IDLE;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign bus_req_o   = ch_en_i & (st_q != ST_IDLE);
  assign bus_we_o    = (st_q == ST_WR);
  assign bus_addr_o  = bus_we_o ? dst_ptr : src_ptr;
  assign bus_size_o  = bus_we_o ? dst_w : src_w;
  assign bus_wdata_o = width_mask(data_q, src_w);
endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int unsigned AW  = 32,
  parameter int unsigned DW  = 32,
  parameter int unsigned CW  = 16,
  parameter int unsigned RAW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  input  logic           preq_i,
  output logic           bus_req_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic           bus_we_o,
  output logic [1:0]     bus_size_o,
  output logic [DW-1:0]  bus_wdata_o,
  input  logic [DW-1:0]  bus_rdata_i,
  input  logic           bus_ready_i,
  input  logic           bus_err_i,
  output logic           irq_o
);
  import dma_pkg::*;

  cfg_t          cfg;
  logic          ch_en, flag_tc, flag_ht, flag_te;
  logic          set_tc, set_ht, set_te;
  logic [AW-1:0] paddr, maddr;
  logic [CW-1:0] cnt_init, cnt_cur;

  dma_regs #(.AW(AW), .CW(CW), .RAW(RAW)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .cnt_cur_i  (cnt_cur),
    .set_tc_i   (set_tc),
    .set_ht_i   (set_ht),
    .set_te_i   (set_te),
    .ch_en_o    (ch_en),
    .cfg_o      (cfg),
    .paddr_o    (paddr),
    .maddr_o    (maddr),
    .cnt_init_o (cnt_init),
    .flag_tc_o  (flag_tc),
    .flag_ht_o  (flag_ht),
    .flag_te_o  (flag_te),
    .irq_o
  );

  dma_engine #(.AW(AW), .DW(DW), .CW(CW)) u_eng (
    .clk_i, .rst_ni,
    .ch_en_i    (ch_en),
    .dir_i      (cfg.dir),
    .circ_i     (cfg.circ),
    .m2m_i      (cfg.m2m),
    .pinc_i     (cfg.pinc),
    .minc_i     (cfg.minc),
    .pw_i       (cfg.pw),
    .mw_i       (cfg.mw),
    .paddr_i    (paddr),
    .maddr_i    (maddr),
    .cnt_init_i (cnt_init),
    .preq_i,
    .bus_req_o, .bus_addr_o, .bus_we_o, .bus_size_o, .bus_wdata_o,
    .bus_rdata_i, .bus_ready_i, .bus_err_i,
    .cnt_o      (cnt_cur),
    .set_tc_o   (set_tc),
    .set_ht_o   (set_ht),
    .set_te_o   (set_te)
  );
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic          bus_ready_i,
  input logic          bus_err_i,
  input logic          irq_o,
  input logic          ch_en,
  input logic          flag_tc,
  input logic          flag_ht,
  input logic          flag_te,
  input logic [CW-1:0] cnt_cur
);
  // R10
  err_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ready_i && bus_err_i |=> !ch_en);
  // R10
  err_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ready_i && bus_err_i |=> flag_te);
  // R11
  irq_has_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_tc || flag_ht || flag_te));
  // R6
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_ready_i && !bus_err_i && (cnt_cur > 1) |=>
      cnt_cur == $past(cnt_cur) - 1'b1);
  // R3
  write_follows_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_we_o) |-> $past(bus_req_o && !bus_we_o && bus_ready_i && !bus_err_i));
endmodule

bind dma_chan dma_chan_chk #(.CW(CW)) u_chk (.*);

// File: tb/dma_chan_test.sv
`timescale 1ns/1ps
module dma_chan_test;
  localparam logic [31:0] K = 32'h5A5A_0000;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        preq = 1'b0;
  logic        bus_req, bus_we, irq;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic        bus_ready, bus_err;
  int          total = 0, bad = 0;
  bit          done_flag = 0;

  typedef struct { logic [31:0] addr; logic [31:0] data; logic [1:0] size; } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  assign bus_ready = bus_req;
  assign bus_err   = (bus_addr[31:28] == 4'hF);
  assign bus_rdata = bus_addr ^ K;

  dma_chan uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .preq_i(preq),
    .bus_req_o(bus_req), .bus_addr_o(bus_addr), .bus_we_o(bus_we),
    .bus_size_o(bus_size), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .bus_ready_i(bus_ready), .bus_err_i(bus_err), .irq_o(irq)
  );

  function automatic logic [31:0] msk(input logic [31:0] d, input logic [1:0] w);
    return (w == 2'd0) ? {24'b0, d[7:0]} : (w == 2'd1) ? {16'b0, d[15:0]} : d;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [1:0] s);
    item_t it;
    it.addr = a; it.data = d; it.size = s;
    exp_q.push_back(it);
  endtask

  task automatic pulse_req();
    @(negedge clk); preq = 1'b1;
    @(negedge clk); preq = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // monitor: every completed write is popped against the scoreboard
  always @(negedge clk) begin
    if (rst_ni && bus_req && bus_we && bus_ready) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R5/R10: unexpected write actual=%h expected=none", bus_addr);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check("R4 dst addr", bus_addr, e.addr);
        check("R3 data", bus_wdata, e.data);
        check("R3 size", {30'b0, bus_size}, {30'b0, e.size});
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pa, ma;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(3'd0, v); check("R1 ctrl", v, 32'h0);
    rd(3'd4, v); check("R1 status", v, 32'h0);
    rd(3'd3, v); check("R1 count", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 req", {31'b0, bus_req}, 32'h0);

    // R3 R4 R5 R9 mem-to-mem, dir 0, pw=32 mw=16, both inc, tcie
    pa = 32'h1000_0000; ma = 32'h2000_0000;
    wr(3'd1, pa); wr(3'd2, ma); wr(3'd3, 32'd4);
    for (int i = 0; i < 4; i++) push(ma + 2 * i, (pa + 4 * i) ^ K, 2'd1);
    wr(3'd0, 32'h0000_2000 | (1 << 9) | (1 << 7) | (2 << 5) | (1 << 4) | (1 << 3) | 1);
    repeat (30) @(negedge clk);
    check("R5 m2m all done", exp_q.size(), 0);
    rd(3'd4, v); check("R9 R8 status", v, 32'h7);
    check("R11 irq tc", {31'b0, irq}, 32'h1);
    rd(3'd3, v); check("R6 count zero", v, 32'h0);
    check("R6 idle at zero", {31'b0, bus_req}, 32'h0);

    // R11 write-one-to-clear
    wr(3'd4, 32'hE);
    rd(3'd4, v); check("R11 cleared", v, 32'h0);
    check("R11 irq low", {31'b0, irq}, 32'h0);
    wr(3'd0, 32'h0);

    // R2 R5 R7 R8 peripheral circular, dir 1, 8 bit, minc only, htie
    pa = 32'h3000_0040; ma = 32'h4000_0000;
    wr(3'd1, pa); wr(3'd2, ma); wr(3'd3, 32'd3);
    wr(3'd0, 32'h0000_1000 | (1 << 4) | (1 << 2) | (1 << 1) | 1);
    repeat (10) @(negedge clk);
    check("R5 no request no access", {31'b0, bus_req}, 32'h0);
    for (int i = 0; i < 2; i++) begin
      push(pa, msk((ma + (i % 3)) ^ K, 2'd0), 2'd0);
      pulse_req();
    end
    rd(3'd4, v); check("R8 half only", v, 32'h5);
    check("R11 irq ht", {31'b0, irq}, 32'h1);
    for (int i = 2; i < 4; i++) begin
      push(pa, msk((ma + (i % 3)) ^ K, 2'd0), 2'd0);
      pulse_req();
    end
    // R2 locked writes while enabled
    wr(3'd1, 32'h3000_0080); wr(3'd2, 32'h4000_0100); wr(3'd3, 32'd9);
    wr(3'd0, 32'h0000_1000 | (1 << 3) | 1);
    rd(3'd1, v); check("R2 paddr locked", v, pa);
    for (int i = 4; i < 7; i++) begin
      push(pa, msk((ma + (i % 3)) ^ K, 2'd0), 2'd0);
      pulse_req();
    end
    check("R7 circular writes", exp_q.size(), 0);
    rd(3'd3, v); check("R7 R2 count after wrap", v, 32'd2);
    rd(3'd4, v); check("R9 tc in circular", v & 32'h2, 32'h2);
    wr(3'd0, 32'h0);
    wr(3'd4, 32'hE);

    // R10 bus error on first read
    wr(3'd1, 32'hF000_0010); wr(3'd2, 32'h5000_0000); wr(3'd3, 32'd2);
    wr(3'd0, 32'h0000_4000 | (1 << 9) | (2 << 7) | (2 << 5) | 1);
    repeat (10) @(negedge clk);
    rd(3'd4, v); check("R10 te flag", v, 32'h9);
    rd(3'd0, v); check("R10 enable cleared", v & 32'h1, 32'h0);
    check("R10 irq", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'hE);

    // R6 enable with count 0
    wr(3'd1, 32'h1000_0000); wr(3'd3, 32'd0);
    wr(3'd0, (1 << 9) | (1 << 3) | 1);
    repeat (10) @(negedge clk);
    rd(3'd3, v); check("R6 zero count", v, 32'h0);
    rd(3'd4, v); check("R6 zero no flags", v, 32'h0);
    wr(3'd0, 32'h0);

    // R7 circular ignored in mem-to-mem, pw=16 pinc, mw=32 minc
    pa = 32'h1100_0000; ma = 32'h2200_0000;
    wr(3'd1, pa); wr(3'd2, ma); wr(3'd3, 32'd2);
    for (int i = 0; i < 2; i++) push(ma + 4 * i, msk((pa + 2 * i) ^ K, 2'd1), 2'd2);
    wr(3'd0, (1 << 9) | (2 << 7) | (1 << 5) | (1 << 4) | (1 << 3) | (1 << 2) | 1);
    repeat (30) @(negedge clk);
    check("R7 m2m no reload writes", exp_q.size(), 0);
    rd(3'd3, v); check("R7 m2m count stays 0", v, 32'h0);
    wr(3'd0, 32'h0);

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule